// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the clocked decision core of a synchronous buck half-bridge driver. It takes a PWM command that has already been digitized into two level flags and turns it into two gate-enable outputs, one for the high-side switch and one for the low-side switch. Three comparator flags report that the lower gate has discharged, that the upper gate has discharged, and that the switch node has fallen. The sequencer uses them to open the next switch as soon as the previous one is really off. A timeout takes over when the switch-node flag is slow.

Two further behaviours sit on top of the basic sequencing. The first is a shutdown window: a PWM input parked at the middle level for longer than a holdoff time drops both gates until the input leaves that level. The second is diode emulation: when enabled, the low-side switch is released at the inductor zero-current crossing, but never before a minimum on-time has passed. A power-good flag gates the whole block. All durations are given in nanoseconds and converted to clock cycles from a clock-period parameter. With the defaults (10 ns clock) these are 3 cycles of blanking, 4 cycles of lower-gate timeout, 24 cycles of holdoff and 35 cycles of minimum on-time.

Top module: `dt_gate_sequencer`

## Requirements
- R1: The PWM flags decode as: `pwm_hi`=1 is a high command whatever `pwm_lo` is. `pwm_hi`=0 with `pwm_lo`=1 is a low command. Both 0 is the mid (three-state) command.
- R2: A high command drops `lg_en` on the first clock edge that samples it. `ug_en` rises on the first later edge that is at least BLANK_CYC+1 edges after that drop and at which `lg_low` is sampled high.
- R3: A low command drops `ug_en` on the first edge that samples it. `lg_en` rises on the first later edge that samples `sw_low` high, or LGTO_CYC edges after the first edge in that wait that sampled `ug_low` high, whichever comes first.
- R4: `ug_en` and `lg_en` are never high in the same cycle. Neither output rises in the cycle right after the other was high.
- R5: A mid command sampled on HOLD_CYC+1 consecutive edges forces both enables low from that last edge on, and they stay low while the command stays mid. A mid command lasting HOLD_CYC edges or fewer changes nothing.
- R6: Shutdown ends on the first edge that samples a high or low command. Sequencing then proceeds as in R2 or R3.
- R7: With `de_en`=1, once the minimum on-time has passed, `lg_en` drops on the first edge that samples `zc_det` high. It stays low while the command remains low.
- R8: With `de_en`=1, `lg_en` stays high for at least MINON_CYC+1 cycles. Neither a zero crossing nor a mid shutdown ends it earlier, and the drop happens on the first edge allowed by both.
- R9: With `de_en`=0, `zc_det` has no effect and `lg_en` stays high for as long as the command is low.
- R10: While `por_ok`=0 both enables are low from the next edge. After `por_ok` rises, the sampled command takes control as in R2 and R3.
- R11: Synchronous active-high `rst` forces both enables low on the next edge and clears all timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | 1 | PWM input above the upper threshold |
| pwm_lo | input | 1 | PWM input below the lower threshold |
| lg_low | input | 1 | Lower gate voltage has fallen below its threshold |
| ug_low | input | 1 | Upper gate-to-source voltage has fallen below its threshold |
| sw_low | input | 1 | Switch node has fallen below its threshold |
| zc_det | input | 1 | Inductor current zero crossing detected |
| de_en | input | 1 | Diode-emulation mode enable |
| por_ok | input | 1 | Supply power-good flag |
| ug_en | output | 1 | High-side gate enable |
| lg_en | output | 1 | Low-side gate enable |

## Verification
The bench models gate fall times with delays it can program, so each edge of the main sequence is tried under two conditions. Rising commands run with a fast lower-gate discharge and then with a slow one, which separates the blanking limit from the feedback wait. Falling commands run with a prompt switch-node flag and then with one that never arrives, which separates the adaptive path from the timeout count. Mid-level pulses one cycle short of the holdoff and sustained ones tell the window boundary apart. In diode emulation, early and late zero crossings, and a mid shutdown during the minimum on-time, show which limit ends low-side conduction; the same crossing in continuous mode must do nothing.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;

    typedef enum logic [1:0] {
        CMD_LO  = 2'd0,
        CMD_HI  = 2'd1,
        CMD_MID = 2'd2
    } pwm_cmd_e;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_HI_WAIT = 3'd1,
        ST_HI_ON   = 3'd2,
        ST_LO_WAIT = 3'd3,
        ST_LO_ON   = 3'd4,
        ST_DE_IDLE = 3'd5,
        ST_SHUT    = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic lg_low;
        logic ug_low;
        logic sw_low;
        logic zc;
    } sense_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_en_t;

    // Round a duration up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int dur_ns, input int clk_ns);
        int c;
        c = (dur_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // High level wins over low level; neither means three-state.
    function automatic pwm_cmd_e decode_pwm(input logic hi, input logic lo);
        if (hi)      return CMD_HI;
        else if (lo) return CMD_LO;
        else         return CMD_MID;
    endfunction

endpackage

// File: rtl/gs_cycle_timer.sv
`timescale 1ns/1ps
module gs_cycle_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    // Counts edges since the last clear, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != LIM)
            cnt <= cnt + W'(1);
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/gs_pwm_decode.sv
`timescale 1ns/1ps
module gs_pwm_decode
    import gs_pkg::*;
#(
    parameter int HOLD_CYC = 24
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pwm_hi,
    input  logic     pwm_lo,
    output pwm_cmd_e cmd,
    output logic     shut
);
    logic is_mid;
    logic hold_done;

    assign cmd    = decode_pwm(pwm_hi, pwm_lo);
    assign is_mid = (cmd == CMD_MID);

    // Holdoff: counts consecutive cycles spent at mid level.
    gs_cycle_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .clr  (!is_mid),
        .done (hold_done)
    );

    assign shut = hold_done && is_mid;
endmodule

// File: rtl/gs_seq_fsm.sv
`timescale 1ns/1ps
module gs_seq_fsm
    import gs_pkg::*;
#(
    parameter int BLANK_CYC = 3,
    parameter int LGTO_CYC  = 4,
    parameter int MINON_CYC = 35
) (
    input  logic     clk,
    input  logic     rst,
    input  pwm_cmd_e cmd,
    input  logic     shut,
    input  sense_t   sense,
    input  logic     de_en,
    input  logic     por_ok,
    output gate_en_t gate
);
    localparam int NTMR = 3;
    localparam int TMR_LIM [NTMR] = '{BLANK_CYC, LGTO_CYC, MINON_CYC};
    localparam int T_BLANK = 0;
    localparam int T_LGTO  = 1;
    localparam int T_MINON = 2;

    seq_state_e st, nxt;
    logic [NTMR-1:0] tmr_clr;
    logic [NTMR-1:0] tmr_done;
    logic blank_done, tmo_done, minon_done;

    assign tmr_clr[T_BLANK] = (st != ST_HI_WAIT);
    assign tmr_clr[T_LGTO]  = !((st == ST_LO_WAIT) && sense.ug_low);
    assign tmr_clr[T_MINON] = (st != ST_LO_ON);

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        gs_cycle_timer #(.LIMIT(TMR_LIM[i])) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .clr  (tmr_clr[i]),
            .done (tmr_done[i])
        );
    end

    assign blank_done = tmr_done[T_BLANK];
    assign tmo_done   = tmr_done[T_LGTO];
    assign minon_done = tmr_done[T_MINON];

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF, ST_SHUT: begin
                if (cmd == CMD_HI)      nxt = ST_HI_WAIT;
                else if (cmd == CMD_LO) nxt = ST_LO_WAIT;
            end
            ST_HI_WAIT: begin
                if (cmd == CMD_LO)                    nxt = ST_LO_WAIT;
                else if (shut)                        nxt = ST_SHUT;
                else if (blank_done && sense.lg_low)  nxt = ST_HI_ON;
            end
            ST_HI_ON: begin
                if (cmd == CMD_LO) nxt = ST_LO_WAIT;
                else if (shut)     nxt = ST_SHUT;
            end
            ST_LO_WAIT: begin
                if (cmd == CMD_HI)                  nxt = ST_HI_WAIT;
                else if (shut)                      nxt = ST_SHUT;
                else if (sense.sw_low || tmo_done)  nxt = ST_LO_ON;
            end
            ST_LO_ON: begin
                if (cmd == CMD_HI)                              nxt = ST_HI_WAIT;
                else if (shut && (!de_en || minon_done))        nxt = ST_SHUT;
                else if (de_en && minon_done && sense.zc)       nxt = ST_DE_IDLE;
            end
            ST_DE_IDLE: begin
                if (cmd == CMD_HI) nxt = ST_HI_WAIT;
                else if (shut)     nxt = ST_SHUT;
            end
            default: nxt = ST_OFF;
        endcase
        if (!por_ok) nxt = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_OFF;
        else     st <= nxt;
    end

    assign gate.hi = (st == ST_HI_ON);
    assign gate.lo = (st == ST_LO_ON);

    // R2: upper enable only after lower gate seen discharged and lower off.
    a_r2_upper_after_lower_low: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.hi) |-> ($past(sense.lg_low) && !$past(gate.lo)));

    // R3: lower enable only after switch node low or timeout, upper off.
    a_r3_lower_after_upper_off: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.lo) |-> (!$past(gate.hi) && ($past(sense.sw_low) || $past(tmo_done))));

    // R5: sustained mid level with no on-time pending drops both gates.
    a_r5_shutdown_clears: assert property (@(posedge clk) disable iff (rst)
        (shut && por_ok && (!de_en || minon_done || !gate.lo)) |=> (!gate.hi && !gate.lo));

    // R8: in diode emulation the lower gate never ends before the minimum on-time.
    a_r8_min_on_time: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate.lo) && $past(!rst) && $past(por_ok) && $past(de_en) && ($past(cmd) != CMD_HI))
        |-> $past(minon_done));

    // R10: power not good forces both gates low.
    a_r10_por_gates_low: assert property (@(posedge clk) disable iff (rst)
        !por_ok |=> (!gate.hi && !gate.lo));
endmodule

// File: rtl/dt_gate_sequencer.sv
`timescale 1ns/1ps
module dt_gate_sequencer
    import gs_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int BLANK_NS = 25,
    parameter int LGTO_NS  = 40,
    parameter int MINON_NS = 350,
    parameter int HOLD_NS  = 240
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic lg_low,
    input  logic ug_low,
    input  logic sw_low,
    input  logic zc_det,
    input  logic de_en,
    input  logic por_ok,
    output logic ug_en,
    output logic lg_en
);
    localparam int BLANK_CYC = ns_to_cyc(BLANK_NS, CLK_NS);
    localparam int LGTO_CYC  = ns_to_cyc(LGTO_NS,  CLK_NS);
    localparam int MINON_CYC = ns_to_cyc(MINON_NS, CLK_NS);
    localparam int HOLD_CYC  = ns_to_cyc(HOLD_NS,  CLK_NS);

    pwm_cmd_e cmd;
    logic     shut;
    sense_t   sense;
    gate_en_t gate;

    assign sense = '{lg_low: lg_low, ug_low: ug_low, sw_low: sw_low, zc: zc_det};

    gs_pwm_decode #(.HOLD_CYC(HOLD_CYC)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .pwm_hi (pwm_hi),
        .pwm_lo (pwm_lo),
        .cmd    (cmd),
        .shut   (shut)
    );

    gs_seq_fsm #(
        .BLANK_CYC (BLANK_CYC),
        .LGTO_CYC  (LGTO_CYC),
        .MINON_CYC (MINON_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .shut   (shut),
        .sense  (sense),
        .de_en  (de_en),
        .por_ok (por_ok),
        .gate   (gate)
    );

    assign ug_en = gate.hi;
    assign lg_en = gate.lo;

    // R4: the two enables are never high together.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(ug_en && lg_en));
endmodule

// File: tb/dt_gate_sequencer_bench.sv
`timescale 1ns/1ps
module dt_gate_sequencer_bench;
    localparam int CLK_NS = 10;
    // Cycle counts derived from the requirement durations.
    localparam int BLANK = (25  + CLK_NS - 1) / CLK_NS;
    localparam int LGTO  = (40  + CLK_NS - 1) / CLK_NS;
    localparam int MINON = (350 + CLK_NS - 1) / CLK_NS;
    localparam int HOLD  = (240 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst, pwm_hi, pwm_lo, lg_low, ug_low, sw_low, zc_det, de_en, por_ok;
    logic ug_en, lg_en;

    dt_gate_sequencer u_dt_gate_sequencer (
        .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .lg_low(lg_low), .ug_low(ug_low), .sw_low(sw_low), .zc_det(zc_det),
        .de_en(de_en), .por_ok(por_ok), .ug_en(ug_en), .lg_en(lg_en)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic  ug;
        logic  lg;
        int    cyc;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    exp_t  e;
    int    cyc = 0;
    int    vectors = 0;
    int    fails = 0;
    int    excl_bad = 0;
    string cur_req = "R11";
    logic [1:0] prev_g = 2'b00;

    // Programmable comparator delays, in cycles after a gate turns off.
    int lf = 2, uf = 2, sf = 3;
    int loff = 1000, uoff = 1000;

    always @(posedge clk) cyc <= cyc + 1;

    // Comparator model: flags follow the gates after the fall delays.
    initial begin lg_low = 1'b1; ug_low = 1'b1; sw_low = 1'b1; end
    always @(negedge clk) begin
        loff = (lg_en === 1'b1) ? 0 : ((loff < 1000) ? loff + 1 : loff);
        uoff = (ug_en === 1'b1) ? 0 : ((uoff < 1000) ? uoff + 1 : uoff);
        lg_low = (loff >= lf);
        ug_low = (uoff >= uf);
        sw_low = (uoff >= sf);
    end

    // Monitor: every gate change is popped against the expected queue.
    always @(negedge clk) begin
        if (!rst || cyc > 0) begin
            if (ug_en === 1'b1 && lg_en === 1'b1) excl_bad++;
            if ({ug_en, lg_en} !== prev_g) begin
                vectors++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s: unexpected change ug=%0b lg=%0b at cycle %0d, expected no change",
                             cur_req, ug_en, lg_en, cyc);
                end else begin
                    e = exp_q.pop_front();
                    if (ug_en !== e.ug || lg_en !== e.lg || cyc != e.cyc) begin
                        fails++;
                        $display("FAIL %s: ug=%0b lg=%0b at cycle %0d, expected ug=%0b lg=%0b at cycle %0d",
                                 e.tag, ug_en, lg_en, cyc, e.ug, e.lg, e.cyc);
                    end
                end
                prev_g = {ug_en, lg_en};
            end
        end
    end

    task automatic expect_ev(input logic u, input logic l, input int c, input string t);
        exp_t x;
        x.ug = u; x.lg = l; x.cyc = c; x.tag = t;
        exp_q.push_back(x);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic set_pwm(input logic h, input logic l);
        pwm_hi = h; pwm_lo = l;
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        int n, m, lon;
        rst = 1'b1; por_ok = 1'b0; de_en = 1'b0; zc_det = 1'b0;
        set_pwm(1'b0, 1'b0);
        wait_n(3);
        chk(ug_en == 1'b0 && lg_en == 1'b0, "R11", {ug_en, lg_en}, 0);

        // R10: command present while power not good -> nothing
        cur_req = "R10";
        set_pwm(1'b1, 1'b0); rst = 1'b0;
        wait_n(6);
        chk(ug_en == 1'b0 && lg_en == 1'b0, "R10", {ug_en, lg_en}, 0);
        por_ok = 1'b1; n = cyc;
        expect_ev(1, 0, n + 1 + imax(BLANK + 1, lf), "R10");
        wait_n(10);

        // R3: falling, switch node resolves first
        cur_req = "R3";
        set_pwm(1'b0, 1'b1); n = cyc;
        expect_ev(0, 0, n + 1, "R3");
        expect_ev(0, 1, imax(n + sf + 1, n + 2), "R3");
        wait_n(10);

        // R1/R2: high flag wins over low flag; fast lower discharge -> blanking limit
        cur_req = "R1";
        set_pwm(1'b1, 1'b1); n = cyc;
        expect_ev(0, 0, n + 1, "R1");
        expect_ev(1, 0, n + 1 + imax(BLANK + 1, lf), "R2");
        wait_n(10);

        // R3: switch node never reports -> timeout after upper-low seen
        cur_req = "R3";
        sf = 1000;
        set_pwm(1'b0, 1'b1); n = cyc;
        expect_ev(0, 0, n + 1, "R3");
        expect_ev(0, 1, n + uf + 1 + LGTO, "R3");
        wait_n(12);

        // R2: slow lower discharge -> feedback limit
        cur_req = "R2";
        lf = 8;
        set_pwm(1'b1, 1'b0); n = cyc;
        expect_ev(0, 0, n + 1, "R2");
        expect_ev(1, 0, n + 1 + imax(BLANK + 1, lf), "R2");
        wait_n(14);
        lf = 2; sf = 3;

        // R5: mid for exactly HOLD edges -> no effect
        cur_req = "R5";
        set_pwm(1'b0, 1'b0);
        wait_n(HOLD);
        set_pwm(1'b1, 1'b0);
        wait_n(5);
        chk(ug_en == 1'b1 && lg_en == 1'b0, "R5", {ug_en, lg_en}, 2);

        // R5: sustained mid -> shutdown, held
        set_pwm(1'b0, 1'b0); n = cyc;
        expect_ev(0, 0, n + HOLD + 1, "R5");
        wait_n(HOLD + 10);
        chk(ug_en == 1'b0 && lg_en == 1'b0, "R5", {ug_en, lg_en}, 0);

        // R6: leave mid to low
        cur_req = "R6";
        set_pwm(1'b0, 1'b1); n = cyc;
        expect_ev(0, 1, n + 2, "R6");
        wait_n(10);

        // R9: zero crossing ignored in continuous mode
        cur_req = "R9";
        zc_det = 1'b1;
        wait_n(40);
        chk(lg_en == 1'b1, "R9", lg_en, 1);
        zc_det = 1'b0;
        wait_n(2);

        // R7: diode emulation, on-time long expired -> off at zero crossing
        cur_req = "R7";
        de_en = 1'b1; zc_det = 1'b1; n = cyc;
        expect_ev(0, 0, n + 1, "R7");
        wait_n(5);
        zc_det = 1'b0;
        wait_n(5);
        chk(lg_en == 1'b0, "R7", lg_en, 0);
        set_pwm(1'b1, 1'b0); n = cyc;
        expect_ev(1, 0, n + 1 + imax(BLANK + 1, lf), "R2");
        wait_n(10);

        // R8: early zero crossing held off by minimum on-time
        cur_req = "R8";
        set_pwm(1'b0, 1'b1); n = cyc; lon = n + 4;
        expect_ev(0, 0, n + 1, "R3");
        expect_ev(0, 1, lon, "R3");
        wait_n(6);
        zc_det = 1'b1; m = cyc;
        expect_ev(0, 0, imax(m + 1, lon + MINON + 1), "R8");
        wait_n(44);
        zc_det = 1'b0;
        set_pwm(1'b1, 1'b0); n = cyc;
        expect_ev(1, 0, n + 1 + imax(BLANK + 1, lf), "R2");
        wait_n(10);

        // R8: mid shutdown held off by minimum on-time
        set_pwm(1'b0, 1'b1); n = cyc; lon = n + 4;
        expect_ev(0, 0, n + 1, "R3");
        expect_ev(0, 1, lon, "R3");
        wait_n(5);
        set_pwm(1'b0, 1'b0); m = cyc;
        expect_ev(0, 0, imax(m + HOLD + 1, lon + MINON + 1), "R8");
        wait_n(60);
        cur_req = "R6";
        set_pwm(1'b1, 1'b0); n = cyc;
        expect_ev(1, 0, n + 1 + imax(BLANK + 1, lf), "R6");
        wait_n(10);

        // R7: late zero crossing acts on its own edge
        cur_req = "R7";
        set_pwm(1'b0, 1'b1); n = cyc;
        expect_ev(0, 0, n + 1, "R3");
        expect_ev(0, 1, n + 4, "R3");
        wait_n(50);
        zc_det = 1'b1; m = cyc;
        expect_ev(0, 0, m + 1, "R7");
        wait_n(10);
        zc_det = 1'b0;
        set_pwm(1'b1, 1'b0); n = cyc;
        expect_ev(1, 0, n + 1 + imax(BLANK + 1, lf), "R2");
        wait_n(10);
        de_en = 1'b0;

        // R10: power loss mid-run, then recovery into low command
        cur_req = "R10";
        por_ok = 1'b0; n = cyc;
        expect_ev(0, 0, n + 1, "R10");
        wait_n(5);
        set_pwm(1'b0, 1'b1);
        wait_n(5);
        chk(ug_en == 1'b0 && lg_en == 1'b0, "R10", {ug_en, lg_en}, 0);
        por_ok = 1'b1; m = cyc;
        expect_ev(0, 1, m + 2, "R10");
        wait_n(10);

        // R11: reset mid-run
        cur_req = "R11";
        rst = 1'b1; n = cyc;
        expect_ev(0, 0, n + 1, "R11");
        wait_n(3);
        chk(ug_en == 1'b0 && lg_en == 1'b0, "R11", {ug_en, lg_en}, 0);
        rst = 1'b0; m = cyc;
        expect_ev(0, 1, m + 2, "R11");
        wait_n(10);

        chk(exp_q.size() == 0, "R4 pending expected events", exp_q.size(), 0);
        chk(excl_bad == 0, "R4 overlap cycles", excl_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * CLK_NS);
        fails++;
        $display("FAIL R4 watchdog: run did not finish, actual cycle %0d expected below %0d", cyc, 200000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule